// File: doc/BRIEF.md
# Shared Peripheral Interrupt Controller

This block gathers the interrupt request lines of many peripherals and folds them onto a small set of general-purpose interrupt inputs of a processor core. Software programs a per-source enable mask, a per-source wakeup enable and a per-source routing field over a small word-addressed register bus. A live view of the raw request lines is also readable, so a handler can tell which of several sources sharing one core input raised the interrupt.

For each core input the block ORs together the enabled sources routed to it and watches the result for rising edges. A rising edge sets a per-input event latch, which is presented to the core. The latch is cleared when the core's in-service indication for that input rises. From that moment the next rising edge is caught again and held for a later event, even while the earlier event is still being serviced. A separate registered wakeup request is raised while the core reports idle and any wakeup-enabled source is requesting.

Top module: `shared_irq_ctrl`

## Requirements
- R1: While and after reset the event latches, queued flags, wakeup request and read data are 0, mask and wakeup-enable registers are 0, and source i is routed to core input i modulo NUM_IRQ.
- R2: A source whose mask bit (register word 0, bit i for source i) is 0 never sets any event latch; with the bit at 1 it reaches its routed input.
- R3: A read (bus_valid=1, bus_write=0) returns data on bus_rdata in the cycle after the strobe, and bus_rdata is 0 in any cycle not following a read. Word 1 returns the synchronized raw request lines, bit i for source i, regardless of mask.
- R4: Routing words start at word 3; source i uses word 3 + i/8, bits [4*(i%8)+3 : 4*(i%8)]. The field value selects the core input; a value of NUM_IRQ or more routes the source nowhere.
- R5: An event latch rises at the second rising clock edge after a routed, enabled source goes high, and not at the first.
- R6: Only rising edges of the combined line of a core input set its latch; a second source asserting while another source on the same input is already high produces no new event.
- R7: An event latch clears at the clock edge where the core's in-service bit for that input is first seen high, and at no other time.
- R8: A rising edge that arrives after the acknowledge, while the in-service bit stays high, sets the latch again, and irq_queued for that input reads 1.
- R9: A second rising edge that arrives while the latch is set and not yet acknowledged merges with the first: one acknowledge leaves the latch at 0.
- R10: If a rising edge is detected in the same cycle the in-service bit rises, the latch stays set.
- R11: wake_req is 1 from the second clock edge after a source with its wakeup-enable bit (word 2, bit i) goes high while core_idle is 1, independently of the mask, and drops at the first edge at which core_idle is 0.
- R12: Writes take effect on a single strobe cycle; a write to the status word 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read strobe |
| src_req | input | NUM_SRC | Peripheral request lines |
| core_ipend | input | NUM_IRQ | Core in-service bits, one per core input |
| core_idle | input | 1 | Core reports idle state |
| irq_latch | output | NUM_IRQ | Event latches presented to the core |
| irq_queued | output | NUM_IRQ | Latch set while the input is in service |
| wake_req | output | 1 | Wakeup request |

## Verification
On every cycle the assertions check that a latch only rises when some request was high two cycles before, that a latch only falls right after an in-service rising edge, that the wakeup request never appears without the idle indication, that read data stays zero outside read responses, and the state right after reset. The routing decode, mask gating, the exact two-cycle detection timing, the shared-line edge suppression, the re-arming after acknowledge, the merging of edges before acknowledge and the edge-with-acknowledge collision can only be shown by the bench's directed scenarios and its vector table of mask, routing and request patterns.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;
  localparam int ADDR_MASK = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_WAKE = 2;
  localparam int ADDR_ROUTE0 = 3;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
  import shared_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_IRQ = 8,
  parameter int SEL_W   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [NUM_SRC-1:0]       src_sync,
  output logic [NUM_SRC-1:0]       mask_q,
  output logic [NUM_SRC-1:0]       wake_en_q,
  output logic [NUM_SRC*SEL_W-1:0] sel_flat,
  output logic [DATA_W-1:0]        bus_rdata
);
  localparam int PER_WORD = DATA_W / SEL_W;

  logic wr_en;
  logic rd_en;
  logic [DATA_W-1:0] rd_word;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      wake_en_q <= '0;
    end else if (wr_en) begin
      if (int'(bus_addr) == ADDR_MASK) mask_q    <= bus_wdata[NUM_SRC-1:0];
      if (int'(bus_addr) == ADDR_WAKE) wake_en_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  // One routing field per source, packed PER_WORD to a register word.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route_field
    localparam int WORD = ADDR_ROUTE0 + i / PER_WORD;
    localparam int LSB  = (i % PER_WORD) * SEL_W;
    logic [SEL_W-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (rst) sel_q <= SEL_W'(i % NUM_IRQ);
      else if (wr_en && int'(bus_addr) == WORD) sel_q <= bus_wdata[LSB +: SEL_W];
    end
    assign sel_flat[i*SEL_W +: SEL_W] = sel_q;
  end

  always_comb begin
    rd_word = '0;
    if (int'(bus_addr) == ADDR_MASK) rd_word[NUM_SRC-1:0] = mask_q;
    if (int'(bus_addr) == ADDR_STAT) rd_word[NUM_SRC-1:0] = src_sync;
    if (int'(bus_addr) == ADDR_WAKE) rd_word[NUM_SRC-1:0] = wake_en_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(bus_addr) == ADDR_ROUTE0 + i / PER_WORD)
        rd_word[(i % PER_WORD)*SEL_W +: SEL_W] = sel_flat[i*SEL_W +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_en ? rd_word : '0;
  end
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int NUM_SRC = 16,
  parameter int NUM_IRQ = 8,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0]       src_sync,
  input  logic [NUM_SRC-1:0]       mask_q,
  input  logic [NUM_SRC*SEL_W-1:0] sel_flat,
  output logic [NUM_IRQ-1:0]       line
);
  // OR of every enabled source routed to each core input; field values
  // outside 0..NUM_IRQ-1 match no input.
  always_comb begin
    line = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (src_sync[i] && mask_q[i] && sel_flat[i*SEL_W +: SEL_W] == SEL_W'(k))
          line[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sirq_edge_latch.sv
module sirq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic ipend,
  output logic latch_q,
  output logic queued
);
  logic line_prev;
  logic ipend_prev;
  logic edge_seen;
  logic ack_rise;

  assign edge_seen = line && !line_prev;
  assign ack_rise  = ipend && !ipend_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev  <= 1'b0;
      ipend_prev <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      line_prev  <= line;
      ipend_prev <= ipend;
      // A new edge wins over a simultaneous acknowledge.
      latch_q    <= (latch_q && !ack_rise) || edge_seen;
    end
  end

  assign queued = latch_q && ipend_prev;
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int NUM_IRQ = 8,
  parameter int SEL_W   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_IRQ-1:0] core_ipend,
  input  logic               core_idle,
  output logic [NUM_IRQ-1:0] irq_latch,
  output logic [NUM_IRQ-1:0] irq_queued,
  output logic               wake_req
);
  logic [NUM_SRC-1:0]       src_sync;
  logic [NUM_SRC-1:0]       mask_q;
  logic [NUM_SRC-1:0]       wake_en_q;
  logic [NUM_SRC*SEL_W-1:0] sel_flat;
  logic [NUM_IRQ-1:0]       line;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sync <= '0;
      wake_req <= 1'b0;
    end else begin
      src_sync <= src_req;
      wake_req <= core_idle && |(src_sync & wake_en_q);
    end
  end

  sirq_regs #(
    .NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .src_sync(src_sync),
    .mask_q(mask_q), .wake_en_q(wake_en_q), .sel_flat(sel_flat),
    .bus_rdata(bus_rdata)
  );

  sirq_route #(
    .NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)
  ) route_i (
    .src_sync(src_sync), .mask_q(mask_q), .sel_flat(sel_flat), .line(line)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chan
    sirq_edge_latch latch_i (
      .clk(clk), .rst(rst),
      .line(line[k]), .ipend(core_ipend[k]),
      .latch_q(irq_latch[k]), .queued(irq_queued[k])
    );
  end
endmodule

// File: rtl/shared_irq_ctrl_chk.sv
module shared_irq_ctrl_chk #(
  parameter int NUM_SRC = 16,
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_IRQ-1:0] core_ipend,
  input logic               core_idle,
  input logic [NUM_IRQ-1:0] irq_latch,
  input logic               wake_req
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (irq_latch == '0 && !wake_req && bus_rdata == '0));

  a_r3_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && !bus_write) |-> bus_rdata == '0);

  a_r11_wake_needs_idle: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(core_idle));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_k
    a_r5_rise_needs_request: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_latch[k]) |-> $past(src_req, 2) != '0);

    a_r7_fall_on_ack: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_latch[k]) |-> ($past(core_ipend[k]) && !$past(core_ipend[k], 2)));
  end
endmodule

bind shared_irq_ctrl shared_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rdata(bus_rdata), .src_req(src_req), .core_ipend(core_ipend),
  .core_idle(core_idle), .irq_latch(irq_latch), .wake_req(wake_req)
);

// File: tb/shared_irq_ctrl_tb_top.sv
module shared_irq_ctrl_tb_top;
  localparam int NUM_SRC = 16;
  localparam int NUM_IRQ = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_valid = 1'b0;
  logic               bus_write = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0]  bus_wdata = '0;
  logic [DATA_W-1:0]  bus_rdata;
  logic [NUM_SRC-1:0] src_req = '0;
  logic [NUM_IRQ-1:0] core_ipend = '0;
  logic               core_idle = 1'b0;
  logic [NUM_IRQ-1:0] irq_latch;
  logic [NUM_IRQ-1:0] irq_queued;
  logic               wake_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shared_irq_ctrl #(
    .NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ), .SEL_W(4),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .core_ipend(core_ipend), .core_idle(core_idle),
    .irq_latch(irq_latch), .irq_queued(irq_queued), .wake_req(wake_req)
  );

  // {mask, route word 3, requests on sources 0..7, expected latches}
  localparam logic [63:0] VEC [6] = '{
    {16'h00FF, 32'h76543210, 8'h05, 8'h05},
    {16'h00FF, 32'h00000000, 8'hF0, 8'h01},
    {16'h000F, 32'h76543210, 8'hFF, 8'h0F},
    {16'h00FF, 32'h99993333, 8'hFF, 8'h08},
    {16'h0000, 32'h76543210, 8'hFF, 8'h00},
    {16'h00FF, 32'h01234567, 8'h03, 8'hC0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_valid = 1'b0;
    data = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 latch during reset", 32'(irq_latch), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 latch", 32'(irq_latch), 0);
    chk("R1 wake", 32'(wake_req), 0);
    bus_rd(0, rd); chk("R1 mask", rd, 0);
    bus_rd(2, rd); chk("R1 wake enable", rd, 0);
    bus_rd(3, rd); chk("R1 R4 route word 3", rd, 32'h76543210);
    bus_rd(4, rd); chk("R1 R4 route word 4", rd, 32'h76543210);

    // Vector table: R2, R4, R5, R7
    bus_wr(4, 32'hFFFFFFFF);
    for (int i = 0; i < 6; i++) begin
      bus_wr(0, 32'(VEC[i][63:48]));
      bus_wr(3, VEC[i][47:16]);
      @(negedge clk);
      src_req = {8'h00, VEC[i][15:8]};
      @(posedge clk); @(negedge clk);
      chk("R5 no latch after one edge", 32'(irq_latch), 0);
      @(posedge clk); @(negedge clk);
      chk("R2 R4 R5 vector latch", 32'(irq_latch), 32'(VEC[i][7:0]));
      src_req = '0;
      core_ipend = '1;
      @(negedge clk);
      core_ipend = '0;
      chk("R7 cleared by ack", 32'(irq_latch), 0);
      repeat (2) @(negedge clk);
    end

    bus_wr(3, 32'h76543210);
    bus_wr(4, 32'h76543210);
    bus_wr(0, 32'h0000FFFF);

    // R6: shared line, second source adds no edge
    @(negedge clk); src_req[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R6 first source latch", 32'(irq_latch[0]), 1);
    core_ipend[0] = 1'b1;
    @(negedge clk);
    chk("R7 clear at ack", 32'(irq_latch[0]), 0);
    src_req[8] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 no event from shared source", 32'(irq_latch[0]), 0);

    // R8: re-arm while in service
    src_req[0] = 1'b0; src_req[8] = 1'b0;
    repeat (3) @(negedge clk);
    src_req[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 latch during service", 32'(irq_latch[0]), 1);
    chk("R8 queued flag", 32'(irq_queued[0]), 1);
    core_ipend[0] = 1'b0;
    @(negedge clk);
    chk("R8 latch held after service ends", 32'(irq_latch[0]), 1);

    // R9: second edge before ack merges
    src_req[0] = 1'b0;
    repeat (3) @(negedge clk);
    src_req[0] = 1'b1;
    repeat (3) @(negedge clk);
    core_ipend[0] = 1'b1;
    @(negedge clk);
    core_ipend[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 merged edge leaves no event", 32'(irq_latch[0]), 0);
    src_req[0] = 1'b0;

    // R10: edge coinciding with ack keeps latch
    repeat (2) @(negedge clk);
    src_req[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    core_ipend[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 latch survives ack", 32'(irq_latch[2]), 1);
    core_ipend[2] = 1'b0; src_req[2] = 1'b0;

    // R3, R12: status and mask gating
    bus_wr(0, 32'h0);
    repeat (2) @(negedge clk);
    src_req = 16'h8001;
    repeat (3) @(negedge clk);
    chk("R2 masked sources no event", 32'(irq_latch[0]), 0);
    bus_rd(1, rd); chk("R3 status raw", rd, 32'h8001);
    bus_wr(1, 32'hFFFF);
    bus_rd(1, rd); chk("R12 status write ignored", rd, 32'h8001);
    bus_rd(0, rd); chk("R12 mask write", rd, 0);
    @(negedge clk);
    chk("R3 rdata quiet", bus_rdata, 0);
    src_req = '0;

    // R11: wakeup
    bus_wr(2, 32'h0020);
    core_idle = 1'b1;
    repeat (2) @(negedge clk);
    src_req[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 wake not yet", 32'(wake_req), 0);
    @(posedge clk); @(negedge clk);
    chk("R11 wake raised with mask clear", 32'(wake_req), 1);
    core_idle = 1'b0;
    @(negedge clk);
    chk("R11 wake drops when busy", 32'(wake_req), 0);
    core_idle = 1'b1; src_req[5] = 1'b0; src_req[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 disabled source no wake", 32'(wake_req), 0);

    finish_run();
  end
endmodule